// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decode

This block counts events in ten steps using a five-stage twisted-ring (Johnson) register. The inverted last stage feeds back into the first stage. The ten legal register patterns are decoded into a ten-bit one-hot output, one line per count value 0 to 9. A carry line comes from the most significant stage and completes one full cycle every ten counts. Designs use it as a divide-by-ten, as a step sequencer or as a glitch-free decade strobe.

Counting is driven by two control inputs, and both are sampled on the single system clock. A rising edge on the step input advances the count while the hold input is low. A falling edge on the hold input advances the count while the step input is high. Each input passes through a two-flop synchronizer before edge detection, and the block takes at most one advance per clock. An asynchronous master reset overrides both control inputs and returns the count to zero.

Top module: `johnson_decade`

## Requirements
- R1: The count runs through ten values, 0 to 9, and returns from 9 to 0 on the next advance.
- R2: `dec_out` is one-hot: bit k is high exactly when the count is k, with bit 0 as the least significant bit.
- R3: `carry_out` is high for counts 0 to 4 and low for counts 5 to 9, so it completes one full cycle every ten advances.
- R4: A low-to-high transition on `cnt_step` advances the count by one when `cnt_hold` is low after the transition.
- R5: A low-to-high transition on `cnt_step` has no effect while `cnt_hold` is high.
- R6: A high-to-low transition on `cnt_hold` advances the count by one when `cnt_step` is high after the transition.
- R7: A high-to-low transition on `cnt_hold` while `cnt_step` is low has no effect. A rising edge on `cnt_hold` and a falling edge on `cnt_step` never advance the count.
- R8: When `mreset` is high, the counter goes to count 0 (all stages low) at once, without waiting for a clock edge, and stays there whatever the control inputs do.
- R9: Each advance changes exactly one stage bit. Any register pattern outside the ten legal ones is replaced by the all-zero pattern on the next clock.
- R10: An input change seen at one rising clock edge shows on the outputs after the third rising edge counted from that one, and not earlier. If both inputs qualify in the same clock, the count advances once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| mreset | input | 1 | Asynchronous master reset, active high |
| cnt_step | input | 1 | Step control; its rising edge counts while `cnt_hold` is low |
| cnt_hold | input | 1 | Hold control; its falling edge counts while `cnt_step` is high |
| dec_out | output | 10 | One-hot decoded count, bit k high at count k |
| carry_out | output | 1 | Decade carry from the most significant stage |

## Verification
The bench walks through every one of the sixteen transitions between pairs of control-input levels, including both inputs changing together. A design that ignored the gating input would count on the rising step edge it is meant to mask, and a design that took both qualifying edges of a single clock would skip a count. The bench follows the count through more than two full decades, so a wrong wrap from 9 to 0 or a carry with its polarity inverted shows up as a decode mismatch. It also checks the output one clock before the expected change, which catches a synchronizer that is one flop short. Finally, it applies master reset between clock edges: a reset taken only on a clock edge would leave the old count visible for that window.

// File: rtl/jdc_pkg.sv
package jdc_pkg;

  // Kind of qualified count event seen in one clock
  typedef enum logic [1:0] {
    ADV_NONE = 2'b00,
    ADV_RISE = 2'b01,
    ADV_FALL = 2'b10,
    ADV_BOTH = 2'b11
  } adv_kind_e;

endpackage

// File: rtl/jdc_sync.sv
module jdc_sync #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             mreset,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [DEPTH-1:0] chain_q;
    always_ff @(posedge clk or posedge mreset) begin
      if (mreset) chain_q <= '0;
      else        chain_q <= {chain_q[DEPTH-2:0], din[i]};
    end
    assign dout[i] = chain_q[DEPTH-1];
  end

endmodule

// File: rtl/jdc_edge.sv
module jdc_edge
  import jdc_pkg::*;
(
  input  logic      clk,
  input  logic      mreset,
  input  logic      step_s,
  input  logic      hold_s,
  output adv_kind_e kind
);

  logic step_q;
  logic hold_q;
  logic rise_ok;
  logic fall_ok;

  always_ff @(posedge clk or posedge mreset) begin
    if (mreset) begin
      step_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      step_q <= step_s;
      hold_q <= hold_s;
    end
  end

  // step rising while hold low; hold falling while step high
  assign rise_ok = step_s & ~step_q & ~hold_s;
  assign fall_ok = hold_q & ~hold_s & step_s;
  assign kind    = adv_kind_e'({fall_ok, rise_ok});

endmodule

// File: rtl/jdc_ring.sv
module jdc_ring #(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              mreset,
  input  logic              advance,
  output logic [STAGES-1:0] stage_q,
  output logic              legal
);

  // twisted-ring step: shift up, inverted top bit enters at bit 0
  function automatic logic [STAGES-1:0] f_twist(input logic [STAGES-1:0] s);
    return {s[STAGES-2:0], ~s[STAGES-1]};
  endfunction

  // a legal pattern has at most one place where neighbours differ
  function automatic logic f_legal(input logic [STAGES-1:0] s);
    int n;
    n = 0;
    for (int i = 0; i < STAGES - 1; i++) begin
      if (s[i] != s[i+1]) n++;
    end
    return (n <= 1);
  endfunction

  logic [STAGES-1:0] stage_d;

  assign legal = f_legal(stage_q);

  always_comb begin
    if (!legal)       stage_d = '0;
    else if (advance) stage_d = f_twist(stage_q);
    else              stage_d = stage_q;
  end

  always_ff @(posedge clk or posedge mreset) begin
    if (mreset) stage_q <= '0;
    else        stage_q <= stage_d;
  end

endmodule

// File: rtl/jdc_decode.sv
module jdc_decode #(
  parameter int STAGES = 5,
  localparam int COUNTS = 2 * STAGES
) (
  input  logic [STAGES-1:0] stage_q,
  output logic [COUNTS-1:0] dec_out,
  output logic              carry_out
);

  // each line is a two-input AND of neighbouring stages
  for (genvar k = 0; k < COUNTS; k++) begin : g_line
    if (k == 0) begin : g_zero
      assign dec_out[k] = ~stage_q[STAGES-1] & ~stage_q[0];
    end else if (k < STAGES) begin : g_fill
      assign dec_out[k] = stage_q[k-1] & ~stage_q[k];
    end else if (k == STAGES) begin : g_full
      assign dec_out[k] = stage_q[STAGES-1] & stage_q[0];
    end else begin : g_drain
      assign dec_out[k] = ~stage_q[k-STAGES-1] & stage_q[k-STAGES];
    end
  end

  assign carry_out = ~stage_q[STAGES-1];

endmodule

// File: rtl/johnson_decade.sv
module johnson_decade
  import jdc_pkg::*;
#(
  parameter int STAGES     = 5,
  parameter int SYNC_DEPTH = 2,
  localparam int COUNTS    = 2 * STAGES
) (
  input  logic              clk,
  input  logic              mreset,
  input  logic              cnt_step,
  input  logic              cnt_hold,
  output logic [COUNTS-1:0] dec_out,
  output logic              carry_out
);

  logic [1:0]        ctl_s;
  adv_kind_e         adv_kind;
  logic              advance;
  logic [STAGES-1:0] stage_q;
  logic              legal;

  jdc_sync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .mreset (mreset),
    .din    ({cnt_hold, cnt_step}),
    .dout   (ctl_s)
  );

  jdc_edge u_edge (
    .clk    (clk),
    .mreset (mreset),
    .step_s (ctl_s[0]),
    .hold_s (ctl_s[1]),
    .kind   (adv_kind)
  );

  // any qualified event gives a single step
  assign advance = (adv_kind != ADV_NONE);

  jdc_ring #(.STAGES(STAGES)) u_ring (
    .clk     (clk),
    .mreset  (mreset),
    .advance (advance),
    .stage_q (stage_q),
    .legal   (legal)
  );

  jdc_decode #(.STAGES(STAGES)) u_dec (
    .stage_q   (stage_q),
    .dec_out   (dec_out),
    .carry_out (carry_out)
  );

endmodule

// File: rtl/jdc_checker.sv
module jdc_checker #(
  parameter int STAGES = 5,
  localparam int COUNTS = 2 * STAGES
) (
  input logic              clk,
  input logic              mreset,
  input logic [STAGES-1:0] stage_q,
  input logic              legal,
  input logic              advance,
  input logic [COUNTS-1:0] dec_out,
  input logic              carry_out
);

  assert_onehot_R2: assert property (@(posedge clk) disable iff (mreset)
    legal |-> ($countones(dec_out) == 1));

  assert_carry_low_half_R3: assert property (@(posedge clk) disable iff (mreset)
    dec_out[0] |-> carry_out);

  assert_carry_high_half_R3: assert property (@(posedge clk) disable iff (mreset)
    dec_out[STAGES] |-> !carry_out);

  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (mreset)
    (legal && !advance) |=> $stable(stage_q));

  assert_step_moves_R10: assert property (@(posedge clk) disable iff (mreset)
    (legal && advance) |=> (stage_q != $past(stage_q)));

  assert_reset_zero_R8: assert property (@(posedge clk)
    mreset |-> (stage_q == '0));

  assert_one_bit_R9: assert property (@(posedge clk) disable iff (mreset)
    legal |=> ($countones(stage_q ^ $past(stage_q)) <= 1));

  assert_recover_R9: assert property (@(posedge clk) disable iff (mreset)
    !legal |=> (stage_q == '0));

endmodule

bind johnson_decade jdc_checker #(.STAGES(STAGES)) u_jdc_chk (
  .clk       (clk),
  .mreset    (mreset),
  .stage_q   (stage_q),
  .legal     (legal),
  .advance   (advance),
  .dec_out   (dec_out),
  .carry_out (carry_out)
);

// File: tb/johnson_decade_bench.sv
`timescale 1ns/1ps
module johnson_decade_bench;

  logic       clk = 1'b0;
  logic       mreset = 1'b1;
  logic       cnt_step = 1'b0;
  logic       cnt_hold = 1'b0;
  logic [9:0] dec_out;
  logic       carry_out;

  int checks = 0;
  int failures = 0;
  int cnt = 0;
  logic cur_a = 1'b0;
  logic cur_b = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  johnson_decade u_johnson_decade (
    .clk       (clk),
    .mreset    (mreset),
    .cnt_step  (cnt_step),
    .cnt_hold  (cnt_hold),
    .dec_out   (dec_out),
    .carry_out (carry_out)
  );

  function automatic logic [10:0] expect_of(input int c);
    logic [10:0] v;
    v = '0;
    v[c] = 1'b1;
    v[10] = (c < 5);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // set both control levels, wait for the synchronizer, compare to model
  task automatic apply(input logic a, input logic b);
    logic adv;
    string tag;
    adv = (!cur_a && a && !b) || (cur_b && !b && a);
    if (!cur_a && a)      tag = b ? "R5 step rise masked" : "R4 step rise counts";
    else if (cur_b && !b) tag = a ? "R6 hold fall counts" : "R7 hold fall masked";
    else                  tag = "R7 no qualifying edge";
    if (!cur_a && a && cur_b && !b) tag = "R10 both edges one step";
    @(negedge clk);
    cnt_step = a;
    cnt_hold = b;
    cur_a = a;
    cur_b = b;
    repeat (3) @(negedge clk);
    if (adv) cnt = (cnt + 1) % 10;
    chk(tag, {carry_out, dec_out}, expect_of(cnt));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset state", {carry_out, dec_out}, expect_of(0));
    mreset = 1'b0;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R9: walk more than two decades with step pulses
    for (int i = 0; i < 25; i++) begin
      logic [9:0] prev;
      prev = dec_out;
      apply(1'b1, 1'b0);
      chk("R9 adjacent line", {1'b0, dec_out}, {1'b0, prev[8:0], prev[9]});
      chk("R1 R2 R3 decade walk", {carry_out, dec_out}, expect_of(cnt));
      apply(1'b0, 1'b0);
    end

    // R10: latency of a step edge
    @(negedge clk);
    cnt_step = 1'b1;
    cur_a = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 not before third edge", {carry_out, dec_out}, expect_of(cnt));
    @(negedge clk);
    cnt = (cnt + 1) % 10;
    chk("R10 after third edge", {carry_out, dec_out}, expect_of(cnt));
    apply(1'b0, 1'b0);

    // R4 R5 R6 R7 R10: every transition between level pairs
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        apply(f[0], f[1]);
        apply(t[0], t[1]);
      end
    end

    // R8: reset between edges, then held against input toggles
    apply(1'b0, 1'b0);
    apply(1'b1, 1'b0);
    @(negedge clk);
    #0.5;
    mreset = 1'b1;
    #0.5;
    chk("R8 async reset", {carry_out, dec_out}, expect_of(0));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cnt_step = ~cnt_step;
      cnt_hold = (i == 1);
    end
    repeat (3) @(negedge clk);
    chk("R8 reset overrides inputs", {carry_out, dec_out}, expect_of(0));
    cnt_step = 1'b0;
    cnt_hold = 1'b0;
    cur_a = 1'b0;
    cur_b = 1'b0;
    cnt = 0;
    @(negedge clk);
    mreset = 1'b0;
    apply(1'b1, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule